// File: doc/BRIEF.md
# Random Replacement Slot Picker

This block chooses which slot of a translation cache a replacement-style write should overwrite. The caller gives the number of slots (`total_i`) and a count of reserved slots at the bottom of the array (`wired_i`). The caller then pulses `req_i`. The picker steps a 32-bit linear congruential generator and takes the upper half of the new state. It reduces that value modulo the number of free slots and adds the reserved count, so the result always falls among the slots that may be replaced.

If the candidate matches the slot the picker returned last time, the picker steps the generator again and repeats. It does this until the slot differs, so the same slot never comes back twice in a row. The reduction uses a bit-serial restoring divider. A normal pick therefore takes about twenty cycles per generator step, and the block reports `busy_o` for that time.

Two cases return at once without touching the generator:
- When only one free slot exists, the picker returns the top slot.
- When the configuration leaves no free slot, the picker returns the top slot and also raises `err_o`.

Top module: `rnd_slot_picker`

## Requirements
- R1: Each generator step replaces the 32-bit state s with (s * 1103515245 + 12345) mod 2^32. The state changes only when a step is taken.
- R2: On a normal pick, the returned index equals ((s >> 16) mod (total - wired)) + wired, where s is the stepped state. The index therefore lies in [wired, total-1].
- R3: A normal pick never returns the index that the previous normal pick returned. On a match, the generator steps again and the candidate is recomputed.
- R4: When total - wired equals 1, the result is total - 1. The generator does not step and the remembered index is left unchanged.
- R5: After reset the state is 1, the remembered index is 0, and `valid_o`, `busy_o` and `err_o` are low.
- R6: The remembered index is loaded only with an index returned by a normal pick. Single-slot and error results do not change it.
- R7: `valid_o` is high for exactly one cycle per accepted request. It is high only when `busy_o` is low. `busy_o` is high from the cycle after a normal request is accepted until its result appears.
- R8: A `req_i` pulse while `busy_o` is high is ignored. It produces no extra result and no extra generator step.
- R9: `total_i` and `wired_i` are sampled when a request is accepted. Changes to them while busy do not affect the result.
- R10: If wired >= total, the picker returns the low 6 bits of total - 1 with `err_o` high in the same cycle as `valid_o`. The generator does not step and the remembered index is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse for a new slot |
| total_i | input | 7 | Number of slots in the array (0 to 64) |
| wired_i | input | 7 | Number of reserved slots at the bottom |
| busy_o | output | 1 | A normal pick is in progress |
| valid_o | output | 1 | One-cycle strobe: `idx_o` and `err_o` hold a fresh result |
| idx_o | output | 6 | Chosen slot index |
| err_o | output | 1 | The configuration left no free slot |

## Verification
The first request after reset is compared with the sequence that starts from state 1 and remembered index 0. This pins down the reset values and the generator arithmetic together. Two-slot ranges are driven back to back, where the candidate often equals the last index, to exercise the retry loop. Random ranges and reserved counts check the modulo-and-offset arithmetic across many divisor widths. Single-slot and no-slot configurations are placed between normal picks; the normal pick that follows still matches the model, which shows the state and remembered index were left alone. During some picks the bench toggles `req_i` and changes the configuration inputs while busy. A result that still matches the first configuration, with no extra strobe, separates correct sampling from leaks of the later inputs.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STEP   = 2'd1,
    ST_REDUCE = 2'd2
  } rsp_state_e;

endpackage

// File: rtl/rsp_lcg_next.sv
module rsp_lcg_next #(
  parameter int unsigned SEED_W = 32,
  parameter logic [SEED_W-1:0] MUL = 32'd1103515245,
  parameter logic [SEED_W-1:0] INC = 32'd12345
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o
);

  // Product is truncated to SEED_W bits: arithmetic wraps modulo 2^SEED_W.
  always_comb begin
    seed_o = seed_i * MUL + INC;
  end

endmodule

// File: rtl/rsp_mod_unit.sv
module rsp_mod_unit #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [DEN_W-1:0] rem_o
);

  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q, num_n;
  logic [DEN_W-1:0] den_q, den_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             done_q, done_n;

  logic [DEN_W:0] trial;
  logic [DEN_W:0] diff;

  always_comb begin
    trial  = {rem_q, num_q[NUM_W-1]};
    diff   = trial - {1'b0, den_q};
    num_n  = num_q;
    den_n  = den_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (start_i) begin
      num_n = num_i;
      den_n = den_i;
      rem_n = '0;
      cnt_n = CNT_W'(NUM_W);
      run_n = 1'b1;
    end else if (run_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_n = diff[DEN_W-1:0];
      end else begin
        rem_n = trial[DEN_W-1:0];
      end
      num_n = num_q << 1;
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      num_q  <= num_n;
      den_q  <= den_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;

  // R2: the remainder handed back is always below the divisor
  a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rem_o < den_q));

  // R2: the divider is never launched with a zero divisor
  a_r2_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (den_i != '0));

endmodule

// File: rtl/rnd_slot_picker.sv
module rnd_slot_picker #(
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned SEED_W    = 32,
  parameter int unsigned TAKE_LSB  = 16,
  parameter logic [SEED_W-1:0] SEED_INIT = 32'd1,
  parameter logic [SEED_W-1:0] LCG_MUL   = 32'd1103515245,
  parameter logic [SEED_W-1:0] LCG_INC   = 32'd12345
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [IDX_W:0]   total_i,
  input  logic [IDX_W:0]   wired_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             err_o
);

  import rsp_pkg::*;

  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned NUM_W = SEED_W - TAKE_LSB;

  rsp_state_e       state_q, state_n;
  logic [SEED_W-1:0] seed_q, seed_n, seed_step;
  logic [IDX_W-1:0] prev_q, prev_n;
  logic [CNT_W-1:0] total_q, total_n;
  logic [CNT_W-1:0] wired_q, wired_n;
  logic [CNT_W-1:0] span_q, span_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             valid_q, valid_n;
  logic             err_q, err_n;

  logic             div_start;
  logic             div_done;
  logic [CNT_W-1:0] div_rem;
  logic [CNT_W-1:0] span_in;
  logic [CNT_W-1:0] last_in;
  logic             bad_in;
  logic [CNT_W-1:0] cand;

  rsp_lcg_next #(
    .SEED_W (SEED_W),
    .MUL    (LCG_MUL),
    .INC    (LCG_INC)
  ) u_lcg (
    .seed_i (seed_q),
    .seed_o (seed_step)
  );

  rsp_mod_unit #(
    .NUM_W (NUM_W),
    .DEN_W (CNT_W)
  ) u_mod (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (seed_step[SEED_W-1:TAKE_LSB]),
    .den_i   (span_q),
    .done_o  (div_done),
    .rem_o   (div_rem)
  );

  always_comb begin
    span_in   = total_i - wired_i;
    last_in   = total_i - 1'b1;
    bad_in    = (wired_i >= total_i);
    cand      = div_rem + wired_q;
    state_n   = state_q;
    seed_n    = seed_q;
    prev_n    = prev_q;
    total_n   = total_q;
    wired_n   = wired_q;
    span_n    = span_q;
    idx_n     = idx_q;
    valid_n   = 1'b0;
    err_n     = 1'b0;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          total_n = total_i;
          wired_n = wired_i;
          span_n  = span_in;
          if (bad_in) begin
            idx_n   = last_in[IDX_W-1:0];
            err_n   = 1'b1;
            valid_n = 1'b1;
          end else if (span_in == CNT_W'(1)) begin
            idx_n   = last_in[IDX_W-1:0];
            valid_n = 1'b1;
          end else begin
            state_n = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        seed_n    = seed_step;
        div_start = 1'b1;
        state_n   = ST_REDUCE;
      end
      ST_REDUCE: begin
        if (div_done) begin
          if (cand == {1'b0, prev_q}) begin
            state_n = ST_STEP;
          end else begin
            idx_n   = cand[IDX_W-1:0];
            prev_n  = cand[IDX_W-1:0];
            valid_n = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seed_q  <= SEED_INIT;
      prev_q  <= '0;
      total_q <= '0;
      wired_q <= '0;
      span_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      seed_q  <= seed_n;
      prev_q  <= prev_n;
      total_q <= total_n;
      wired_q <= wired_n;
      span_q  <= span_n;
      idx_q   <= idx_n;
      valid_q <= valid_n;
      err_q   <= err_n;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign err_o   = err_q;

  // R1: the generator state moves only in the step state
  a_r1_seed_moves_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_STEP) |=> $stable(seed_q));

  // R2: a normal result lies inside the free window
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o) |-> (({1'b0, idx_o} >= wired_q) && ({1'b0, idx_o} < total_q)));

  // R3: a normal pick differs from the index remembered before it
  a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o && (span_q != CNT_W'(1))) |-> (idx_o != $past(prev_q)));

  // R4: the single-slot case hands back the top slot
  a_r4_single_top: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o && (span_q == CNT_W'(1))) |-> ({1'b0, idx_o} == total_q - 1'b1));

  // R7: a result appears only while idle
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

  // R9: sampled configuration is frozen while busy
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(total_q) && $stable(wired_q)));

  // R10: error flag only with a strobe, carrying the top slot
  a_r10_err_top: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (valid_o && (idx_o == IDX_W'(total_q - 1'b1))));

endmodule

// File: tb/sim_rnd_slot_picker.sv
`timescale 1ns/1ps
module sim_rnd_slot_picker;

  logic       clk;
  logic       rst_n;
  logic       req_i;
  logic [6:0] total_i;
  logic [6:0] wired_i;
  logic       busy_o;
  logic       valid_o;
  logic [5:0] idx_o;
  logic       err_o;

  int n_chk;
  int n_bad;
  logic [31:0] m_seed;
  int          m_prev;

  rnd_slot_picker u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .total_i (total_i),
    .wired_i (wired_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .idx_o   (idx_o),
    .err_o   (err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model_pick(input int tot, input int wir, output int idx, output bit err);
    int c;
    err = 1'b0;
    if (wir >= tot) begin
      idx = (tot - 1) & 63;
      err = 1'b1;
    end else if (tot - wir == 1) begin
      idx = tot - 1;
    end else begin
      do begin
        m_seed = m_seed * 32'd1103515245 + 32'd12345;
        c = (int'(m_seed[31:16]) % (tot - wir)) + wir;
      end while (c == m_prev);
      m_prev = c;
      idx = c;
    end
  endtask

  // One request; noise=1 toggles req and the config while busy (R8, R9)
  task automatic do_req(input int tot, input int wir, input bit noise, input string rq);
    int  exp_idx;
    bit  exp_err;
    int  waited;
    bit  got;
    model_pick(tot, wir, exp_idx, exp_err);
    @(negedge clk);
    req_i   = 1'b1;
    total_i = 7'(tot);
    wired_i = 7'(wir);
    @(negedge clk);
    req_i = 1'b0;
    got = valid_o;
    if (!got) begin
      chk(busy_o == 1'b1, "R7", "busy after accept", int'(busy_o), 1);
    end
    waited = 0;
    while (!got && waited < 5000) begin
      if (noise) begin
        req_i   = 1'($urandom_range(0, 1));
        total_i = 7'($urandom_range(0, 64));
        wired_i = 7'($urandom_range(0, 64));
      end
      @(negedge clk);
      waited++;
      got = valid_o;
      if (got) req_i = 1'b0;
    end
    chk(got, rq, "result strobe seen", int'(got), 1);
    chk(int'(idx_o) == exp_idx, rq, "index", int'(idx_o), exp_idx);
    chk(err_o == exp_err, rq, "error flag", int'(err_o), int'(exp_err));
    @(negedge clk);
    chk(valid_o == 1'b0, "R7", "strobe lasts one cycle", int'(valid_o), 0);
    chk(busy_o == 1'b0, "R8", "no extra pick after noise", int'(busy_o), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    n_chk   = 0;
    n_bad   = 0;
    m_seed  = 32'd1;
    m_prev  = 0;
    rst_n   = 1'b0;
    req_i   = 1'b0;
    total_i = '0;
    wired_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R5", "valid after reset", int'(valid_o), 0);
    chk(busy_o == 1'b0, "R5", "busy after reset", int'(busy_o), 0);
    chk(err_o == 1'b0, "R5", "err after reset", int'(err_o), 0);

    // R5 R1: first pick follows from state 1, remembered 0
    do_req(16, 0, 1'b0, "R5");
    do_req(64, 0, 1'b0, "R1");
    // R4 then R6: single slot leaves state and memory alone
    do_req(8, 7, 1'b0, "R4");
    do_req(32, 4, 1'b0, "R6");
    // R10: no free slot, including total of zero
    do_req(8, 9, 1'b0, "R10");
    do_req(0, 0, 1'b0, "R10");
    do_req(5, 5, 1'b0, "R10");
    do_req(20, 3, 1'b0, "R6");
    // R3: two-slot window forces frequent retries
    for (int i = 0; i < 12; i++) do_req(10, 8, 1'b0, "R3");
    // R8 R9: requests and config churn while busy
    for (int i = 0; i < 6; i++) do_req(48, 16, 1'b1, "R9");
    // R2: random windows, some single and error configs mixed in
    for (int i = 0; i < 80; i++) begin
      int t;
      int w;
      t = $urandom_range(1, 64);
      w = $urandom_range(0, t - 1);
      if ($urandom_range(0, 9) == 0) w = $urandom_range(t, 64);
      do_req(t, w, 1'($urandom_range(0, 1)), "R2");
    end
    finish_run();
  end

endmodule